// File: doc/BRIEF.md
# Period-Aligned Sum-of-Squares Accumulator

This block builds, for several measured channels such as inverter output voltages and load currents, the running sum of squared samples over one period of the generated sine reference. The control loop supplies one set of channel samples per switching cycle. It raises a strobe once the PWM update is done, and the block squares and accumulates those samples during the otherwise idle second half of that cycle. One multiplier serves every channel, one channel per clock.

A pulse from the sine reference phase wrap marks the end of a period. On it, the block copies each channel's sum and the number of samples taken into output registers, then clears its accumulators for the next period. A host microcontroller reads these registers and does the division and square root to get effective values. A valid flag tells the host that a fresh result is present. An overwrite flag reports a result that was replaced before the host read it.

Top module: `ssq_period_accum`

## Requirements
- R1: After reset, busy, res_valid and res_overwrite are 0, every field of sum_out is 0 and cnt_out is 0.
- R2: Each channel k takes its sample from smp_data bits [k*DW +: DW] as a signed two's complement value. The square of that value is added to channel k's running sum.
- R3: A period_wrap pulse copies all running sums into sum_out (channel k at bits [k*AW +: AW]) and the sample count into cnt_out, then clears the running sums and the count. sum_out and cnt_out hold steady between such copies.
- R4: If period_wrap arrives while a sample is still being processed, the copy waits until that sample is fully added. A sample whose strobe falls in the same cycle as period_wrap belongs to the following period.
- R5: A single shared multiplier is used. After an accepted strobe, busy is 1 for exactly NCH cycles, and the channels are processed in ascending order, one per cycle.
- R6: res_valid becomes 1 with each copy and returns to 0 after a host_rd pulse.
- R7: res_overwrite becomes 1 when a copy happens while res_valid is 1 and host_rd is not pulsed in that same cycle. host_rd clears it.
- R8: A running sum that would exceed 2^AW-1 stays at 2^AW-1, and the count stops at MAX_SAMPLES.
- R9: AW = 2*DW + clog2(MAX_SAMPLES+1). MAX_SAMPLES samples of the most negative value therefore accumulate exactly, with no saturation.
- R10: A strobe that arrives while busy is 1 is ignored. It is neither counted nor accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe, once per switching cycle |
| smp_data | input | NCH*DW | Packed signed channel samples |
| period_wrap | input | 1 | Sine reference phase-wrap pulse |
| host_rd | input | 1 | Host has read the result registers |
| busy | output | 1 | Squaring and accumulation in progress |
| sum_out | output | NCH*AW | Latched per-channel sums of squares |
| cnt_out | output | CNTW | Latched number of samples in the period |
| res_valid | output | 1 | Fresh result present |
| res_overwrite | output | 1 | A result was replaced before being read |

## Verification
The bench sends period_wrap while a sample is still being processed. A design that copied at once would report a sum missing that sample's square. It also lines up a strobe with the wrap, and a design that put that sample in the closing period would show a count and sum one sample too high. Further cases are a second strobe while busy, which would double the contribution if it were taken, and long runs of the most negative value. Those runs show that a full MAX_SAMPLES window stays exact and that a longer run clamps instead of wrapping to a small number. Finally, the bench pairs a host read with a copy in the same cycle, where a wrongly ordered flag update would raise a false overwrite.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  typedef enum logic [0:0] {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_t;
endpackage

// File: rtl/ssq_seq.sv
module ssq_seq #(
  parameter int NCH = 3,
  parameter int DW  = 12,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [NCH*DW-1:0] smp_data,
  output logic              busy,
  output logic              smp_accept,
  output logic              step_en,
  output logic [CHW-1:0]    step_ch,
  output logic [DW-1:0]     step_sample
);
  import ssq_pkg::*;

  localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

  seq_state_t        state_q;
  logic [CHW-1:0]    idx_q;
  logic [NCH*DW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      hold_q  <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (smp_valid) begin
            hold_q  <= smp_data;
            idx_q   <= '0;
            state_q <= SEQ_RUN;
          end
        end
        default: begin
          if (idx_q == LAST_CH) begin
            idx_q   <= '0;
            state_q <= SEQ_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy        = (state_q == SEQ_RUN);
  assign smp_accept  = smp_valid && (state_q == SEQ_IDLE);
  assign step_en     = busy;
  assign step_ch     = idx_q;
  assign step_sample = hold_q[idx_q*DW +: DW];
endmodule

// File: rtl/ssq_square.sv
module ssq_square #(
  parameter int DW = 12,
  localparam int SW = 2 * DW
) (
  input  logic [DW-1:0] sample,
  output logic [SW-1:0] square
);
  function automatic logic [SW-1:0] sq_of(input logic [DW-1:0] x);
    logic signed [SW-1:0] sx;
    logic signed [SW-1:0] p;
    sx = SW'($signed(x));
    p  = sx * sx;
    return $unsigned(p);
  endfunction

  assign square = sq_of(sample);
endmodule

// File: rtl/ssq_acc_bank.sv
module ssq_acc_bank #(
  parameter int NCH = 3,
  parameter int SW  = 24,
  parameter int AW  = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step_en,
  input  logic [CHW-1:0]    step_ch,
  input  logic [SW-1:0]     step_sq,
  output logic [NCH*AW-1:0] acc_flat
);
  function automatic logic [AW-1:0] sat_add(input logic [AW-1:0] a,
                                            input logic [SW-1:0] b);
    logic [AW:0] s;
    s = {1'b0, a} + {{(AW + 1 - SW){1'b0}}, b};
    return s[AW] ? {AW{1'b1}} : s[AW-1:0];
  endfunction

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [AW-1:0] acc_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
      end else if (clr) begin
        acc_q <= '0;
      end else if (step_en && (step_ch == CHW'(g))) begin
        acc_q <= sat_add(acc_q, step_sq);
      end
    end
    assign acc_flat[g*AW +: AW] = acc_q;
  end
endmodule

// File: rtl/ssq_result.sv
module ssq_result #(
  parameter int NCH  = 3,
  parameter int AW   = 32,
  parameter int CNTW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch,
  input  logic              host_rd,
  input  logic [NCH*AW-1:0] acc_flat,
  input  logic [CNTW-1:0]   cnt_in,
  output logic [NCH*AW-1:0] sum_out,
  output logic [CNTW-1:0]   cnt_out,
  output logic              res_valid,
  output logic              res_overwrite
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_out       <= '0;
      cnt_out       <= '0;
      res_valid     <= 1'b0;
      res_overwrite <= 1'b0;
    end else if (latch) begin
      sum_out       <= acc_flat;
      cnt_out       <= cnt_in;
      res_valid     <= 1'b1;
      res_overwrite <= res_valid && !host_rd;
    end else if (host_rd) begin
      res_valid     <= 1'b0;
      res_overwrite <= 1'b0;
    end
  end
endmodule

// File: rtl/ssq_period_accum.sv
module ssq_period_accum #(
  parameter int NCH         = 3,
  parameter int DW          = 12,
  parameter int MAX_SAMPLES = 2000,
  localparam int CNTW = $clog2(MAX_SAMPLES + 1),
  localparam int AW   = 2 * DW + CNTW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [NCH*DW-1:0] smp_data,
  input  logic              period_wrap,
  input  logic              host_rd,
  output logic              busy,
  output logic [NCH*AW-1:0] sum_out,
  output logic [CNTW-1:0]   cnt_out,
  output logic              res_valid,
  output logic              res_overwrite
);
  localparam int SW  = 2 * DW;
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [CNTW-1:0] CNT_MAX = CNTW'(MAX_SAMPLES);

  logic              smp_accept;
  logic              step_en;
  logic [CHW-1:0]    step_ch;
  logic [DW-1:0]     step_sample;
  logic [SW-1:0]     step_sq;
  logic [NCH*AW-1:0] acc_flat;
  logic              wrap_pend_q;
  logic              latch_evt;
  logic              acc_clr;
  logic [CNTW-1:0]   cnt_q;

  ssq_seq #(.NCH(NCH), .DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .smp_data   (smp_data),
    .busy       (busy),
    .smp_accept (smp_accept),
    .step_en    (step_en),
    .step_ch    (step_ch),
    .step_sample(step_sample)
  );

  ssq_square #(.DW(DW)) u_sq (
    .sample(step_sample),
    .square(step_sq)
  );

  // Boundary closes only when no sample is in flight.
  assign latch_evt = (wrap_pend_q || period_wrap) && !busy;
  assign acc_clr   = latch_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_pend_q <= 1'b0;
    end else if (latch_evt) begin
      wrap_pend_q <= 1'b0;
    end else if (period_wrap) begin
      wrap_pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (latch_evt) begin
      cnt_q <= smp_accept ? CNTW'(1) : '0;
    end else if (smp_accept && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  ssq_acc_bank #(.NCH(NCH), .SW(SW), .AW(AW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (acc_clr),
    .step_en (step_en),
    .step_ch (step_ch),
    .step_sq (step_sq),
    .acc_flat(acc_flat)
  );

  ssq_result #(.NCH(NCH), .AW(AW), .CNTW(CNTW)) u_res (
    .clk          (clk),
    .rst_n        (rst_n),
    .latch        (latch_evt),
    .host_rd      (host_rd),
    .acc_flat     (acc_flat),
    .cnt_in       (cnt_q),
    .sum_out      (sum_out),
    .cnt_out      (cnt_out),
    .res_valid    (res_valid),
    .res_overwrite(res_overwrite)
  );
endmodule

// File: rtl/ssq_checker.sv
module ssq_checker #(
  parameter int NCH = 3,
  parameter int MAX_SAMPLES = 2000,
  parameter int AW = 32,
  parameter int CNTW = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              smp_accept,
  input logic              step_en,
  input logic [CHW-1:0]    step_ch,
  input logic              latch_evt,
  input logic              acc_clr,
  input logic              host_rd,
  input logic [NCH*AW-1:0] sum_out,
  input logic [CNTW-1:0]   cnt_out,
  input logic              res_valid,
  input logic              res_overwrite
);
  localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

  // R5
  seq_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_accept |=> busy && (step_ch == '0));
  // R5
  seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step_ch != LAST_CH) |=> busy && (step_ch == CHW'($past(step_ch) + 1'b1)));
  // R5
  seq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step_ch == LAST_CH) |=> !busy);
  // R4
  latch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |-> !step_en && acc_clr);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_evt |=> $stable(sum_out) && $stable(cnt_out));
  // R6
  valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> res_valid);
  // R6
  valid_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !latch_evt) |=> !res_valid && !res_overwrite);
  // R7
  ovw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_evt && res_valid && !host_rd) |=> res_overwrite);
  // R7
  ovw_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_overwrite |-> res_valid);
  // R8
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_out <= CNTW'(MAX_SAMPLES));
endmodule

bind ssq_period_accum ssq_checker #(
  .NCH(NCH), .MAX_SAMPLES(MAX_SAMPLES), .AW(AW), .CNTW(CNTW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .smp_accept(smp_accept),
  .step_en(step_en), .step_ch(step_ch), .latch_evt(latch_evt),
  .acc_clr(acc_clr), .host_rd(host_rd), .sum_out(sum_out),
  .cnt_out(cnt_out), .res_valid(res_valid), .res_overwrite(res_overwrite)
);

// File: tb/sim_ssq_period_accum.sv
module sim_ssq_period_accum;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int DW = 8;
  localparam int MAXS = 7;
  localparam int CNTW = 3;
  localparam int AW = 2 * DW + CNTW;
  localparam longint SAT = (64'sd1 <<< AW) - 1;

  logic clk = 0, rst_n = 0, smp_valid = 0, period_wrap = 0, host_rd = 0;
  logic [NCH*DW-1:0] smp_data = '0;
  logic busy, res_valid, res_overwrite;
  logic [NCH*AW-1:0] sum_out;
  logic [CNTW-1:0] cnt_out;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssq_period_accum #(.NCH(NCH), .DW(DW), .MAX_SAMPLES(MAXS)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .period_wrap(period_wrap), .host_rd(host_rd), .busy(busy),
    .sum_out(sum_out), .cnt_out(cnt_out), .res_valid(res_valid),
    .res_overwrite(res_overwrite));

  // rows: {a0,a1,a2,b0,b1,b2}, two samples per period
  localparam logic [47:0] VEC [6] = '{
    48'h01_02_03_04_05_06, 48'hFF_FE_FD_00_00_00, 48'h80_7F_00_80_7F_01,
    48'h10_F0_20_E0_30_D0, 48'h00_00_00_00_00_00, 48'h7F_80_C3_3C_81_11};

  function automatic longint sqv(input logic [7:0] x);
    longint v;
    v = longint'($signed(x));
    return v * v;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint chan_sum(input int k);
    return longint'(sum_out[k*AW +: AW]);
  endfunction

  task automatic send(input logic [7:0] c0, input logic [7:0] c1, input logic [7:0] c2);
    @(negedge clk); smp_data = {c2, c1, c0}; smp_valid = 1;
    @(negedge clk); smp_valid = 0;
    repeat (NCH + 1) @(negedge clk);
  endtask

  task automatic wrap();
    @(negedge clk); period_wrap = 1;
    @(negedge clk); period_wrap = 0;
    @(negedge clk);
  endtask

  task automatic hread();
    @(negedge clk); host_rd = 1;
    @(negedge clk); host_rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 valid", res_valid, 0);
    check("R1 overwrite", res_overwrite, 0);
    check("R1 sum", longint'(sum_out == '0), 1);
    check("R1 cnt", cnt_out, 0);

    // R2 R3 R6 table walk
    for (int i = 0; i < 6; i++) begin
      logic [47:0] v;
      v = VEC[i];
      send(v[47:40], v[39:32], v[31:24]);
      send(v[23:16], v[15:8], v[7:0]);
      wrap();
      for (int k = 0; k < NCH; k++)
        check("R2 R3 sum", chan_sum(k),
              sqv(v[47-8*k -: 8]) + sqv(v[23-8*k -: 8]));
      check("R3 cnt", cnt_out, 2);
      check("R6 valid set", res_valid, 1);
      check("R7 no overwrite", res_overwrite, 0);
      hread();
      check("R6 valid clr", res_valid, 0);
    end

    // R5 busy length
    @(negedge clk); smp_data = {8'd1, 8'd1, 8'd1}; smp_valid = 1;
    for (int c = 0; c < NCH; c++) begin
      @(negedge clk); smp_valid = 0;
      check("R5 busy high", busy, 1);
    end
    @(negedge clk);
    check("R5 busy low", busy, 0);
    wrap(); hread();

    // R4 wrap while busy: in-flight sample belongs to closing period
    @(negedge clk); smp_data = {8'd3, 8'd2, 8'hF6}; smp_valid = 1;
    @(negedge clk); smp_valid = 0; period_wrap = 1;
    @(negedge clk); period_wrap = 0;
    repeat (NCH + 2) @(negedge clk);
    check("R4 deferred ch0", chan_sum(0), 100);
    check("R4 deferred ch2", chan_sum(2), 9);
    check("R4 deferred cnt", cnt_out, 1);
    hread();

    // R4 strobe coinciding with wrap goes to next period
    send(8'd5, 8'd0, 8'd0);
    @(negedge clk); smp_data = {8'd0, 8'd0, 8'd7}; smp_valid = 1; period_wrap = 1;
    @(negedge clk); smp_valid = 0; period_wrap = 0;
    repeat (NCH + 1) @(negedge clk);
    check("R4 same-cycle old", chan_sum(0), 25);
    check("R4 same-cycle old cnt", cnt_out, 1);
    hread();
    wrap();
    check("R4 same-cycle new", chan_sum(0), 49);
    check("R4 same-cycle new cnt", cnt_out, 1);
    hread();

    // R10 strobe while busy ignored
    @(negedge clk); smp_data = {8'd0, 8'd0, 8'd4}; smp_valid = 1;
    @(negedge clk); smp_data = {8'd9, 8'd9, 8'd9};
    @(negedge clk); smp_valid = 0;
    repeat (NCH + 1) @(negedge clk);
    wrap();
    check("R10 ignored sum ch0", chan_sum(0), 16);
    check("R10 ignored sum ch1", chan_sum(1), 0);
    check("R10 ignored cnt", cnt_out, 1);

    // R7 overwrite: latch again without read
    send(8'd2, 8'd0, 8'd0);
    wrap();
    check("R7 overwrite set", res_overwrite, 1);
    check("R7 valid kept", res_valid, 1);
    hread();
    check("R7 overwrite clr", res_overwrite, 0);
    // R7 read in same cycle as latch: no overwrite
    wrap();
    @(negedge clk); period_wrap = 1; host_rd = 1;
    @(negedge clk); period_wrap = 0; host_rd = 0;
    check("R7 read+latch valid", res_valid, 1);
    check("R7 read+latch overwrite", res_overwrite, 0);
    hread();

    // R9 full window exact
    for (int n = 0; n < MAXS; n++) send(8'h80, 8'h80, 8'h00);
    wrap();
    check("R9 exact sum", chan_sum(0), longint'(MAXS) * 16384);
    check("R9 exact cnt", cnt_out, MAXS);
    hread();

    // R8 saturation
    for (int n = 0; n < 40; n++) send(8'h80, 8'h01, 8'h00);
    wrap();
    check("R8 sum saturates", chan_sum(0), SAT);
    check("R8 other channel", chan_sum(1), 40);
    check("R8 cnt saturates", cnt_out, MAXS);
    hread();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule